// File: doc/BRIEF.md
# Release Ring Consumer

This block is the device end of a release ring: an eight-slot circular queue in which a host processor places commands that hand buffers back to buffer pools. The host fills slot storage through a word-wide write port, one header word and eight descriptor words per slot. The block keeps a consumer index, decides whether the slot it points at holds a fresh command, and presents each fresh, well-formed command on a valid/ready output as a buffer count plus eight (address, pool) pairs.

Freshness is judged in one of two ways, chosen by a mode register. In valid-bit mode the block compares the slot header's top bit with the phase bit of its own consumer index, a phase that flips each time the index wraps from slot 7 back to slot 0, so the host never has to write an index register. In index mode the host writes a producer index register and every slot between consumer and producer is pending. A threshold register arms a ring interrupt that fires once a chosen number of entries has been drained. Malformed commands are drained and dropped, and a sticky error flag records that this happened.

Top module: `relring_consumer`

## Requirements
- R1: After reset the consumer index reads 8 (slot 0, phase 1), the producer index reads 8, the mode reads 2, the threshold reads 0, and out_valid, err_flag and ring_irq are 0.
- R2: In mode 2 (valid-bit) the slot at the consumer index is pending when bit 7 of its header word equals bit 3 of the consumer index; the header word (wr_word 0) holds the command byte in bits 7:0 (bit 7 valid bit, bits 6:4 command, bits 3:0 buffer count) and the header pool in bits 15:8, and a pending, well-formed command drives out_valid with out_count equal to its buffer count.
- R3: In valid-bit mode a slot whose header bit 7 differs from the consumer phase is neither presented nor consumed, whatever its other fields hold; the consumer index stays put.
- R4: The consumer index (register 1, bits 3:0) advances by exactly one for each accepted entry and holds otherwise; going from slot 7 to slot 0 toggles bit 3, so the polarity expected in later slots flips.
- R5: Descriptor k (0..7) is written as wr_word k+1, with the address in bits ADDR_W-1:0 and a pool in the next POOL_W bits; out_addr lane k carries that address; with command 2 every out_pool lane carries header pool bits POOL_W-1:0, with command 3 lane k carries descriptor k's own pool.
- R6: A pending entry whose command is neither 2 nor 3, or whose count is 0 or above 8, is consumed in one cycle with out_valid low, and err_flag rises and stays high until reset.
- R7: In mode 0 or 1 (index modes, and likewise mode 3) the slot is pending exactly when the 4-bit producer index (register 0) differs from the 4-bit consumer index; the header valid bit is ignored.
- R8: Register 1 bits 6:4 read 7 minus the distance, modulo 8, from the consumer slot to the producer slot.
- R9: With a nonzero threshold (register 3), ring_irq rises when the number of entries drained since the last threshold write reaches the threshold; writing register 3 clears ring_irq and that count; with threshold 0 ring_irq never rises.
- R10: With out_ready held high and entries pending, one entry is consumed every clock cycle.
- R11: Register 1 is read-only; writes to it leave the consumer index unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Slot storage write strobe |
| wr_slot | input | 3 | Slot being written |
| wr_word | input | 4 | 0 = header, 1..8 = descriptor 0..7, others ignored |
| wr_data | input | DATA_W | Write data |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | 0 producer, 1 consumer, 2 mode, 3 threshold |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for reg_addr |
| out_valid | output | 1 | A well-formed command is presented |
| out_ready | input | 1 | Downstream accepts the command |
| out_count | output | 4 | Buffer count of the command |
| out_addr | output | 8*ADDR_W | Buffer addresses, lane k at k*ADDR_W |
| out_pool | output | 8*POOL_W | Pool per buffer, lane k at k*POOL_W |
| err_flag | output | 1 | Sticky malformed-command flag |
| ring_irq | output | 1 | Drain-threshold interrupt |

## Verification
A wrong consumer index or phase shows at once at the ports: either a stale slot is presented on the very cycle after the index moves, or a fresh slot is never presented, and register 1 reads a different value in the cycle following any acceptance. The bench therefore keeps its own model of slot and phase and compares the register and the output lanes after every single entry, across many wraps of the ring. A drain counter that slips shows within one entry as ring_irq rising early or late, and a mis-decoded command shows as a missing handshake or a spurious error flag on that same entry.

// File: rtl/relring_pkg.sv
package relring_pkg;
    localparam int RING_N = 8;
    localparam int SLOT_W = 3;
    localparam int IDX_W  = SLOT_W + 1;
    localparam int BUF_N  = 8;
    localparam int WSEL_W = 4;

    localparam logic [1:0] MODE_IDX_UC = 2'd0;
    localparam logic [1:0] MODE_IDX_C  = 2'd1;
    localparam logic [1:0] MODE_VBIT   = 2'd2;

    typedef enum logic [2:0] {
        CMD_ONE_POOL = 3'd2,
        CMD_PER_BUF  = 3'd3
    } cmd_e;

    typedef enum logic [1:0] {
        REG_PROD   = 2'd0,
        REG_CONS   = 2'd1,
        REG_MODE   = 2'd2,
        REG_THRESH = 2'd3
    } reg_e;

    typedef struct packed {
        logic       vbit;
        logic [2:0] cmd;
        logic [3:0] cnt;
    } verb_t;

    typedef struct packed {
        logic [7:0] pool;
        verb_t      verb;
    } hdr_t;

    function automatic logic verb_ok(verb_t v);
        return ((v.cmd == CMD_ONE_POOL) || (v.cmd == CMD_PER_BUF))
               && (v.cnt != 4'd0) && (v.cnt <= 4'(BUF_N));
    endfunction

    function automatic logic [SLOT_W-1:0] slot_dist(logic [SLOT_W-1:0] from_s,
                                                    logic [SLOT_W-1:0] to_s);
        return to_s - from_s;
    endfunction
endpackage

// File: rtl/relring_store.sv
module relring_store
    import relring_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    wr_en,
    input  logic [SLOT_W-1:0]       wr_slot,
    input  logic [WSEL_W-1:0]       wr_word,
    input  logic [DATA_W-1:0]       wr_data,
    input  logic [SLOT_W-1:0]       rd_slot,
    output hdr_t                    rd_hdr,
    output logic [BUF_N*DATA_W-1:0] rd_desc
);
    hdr_t              hdr_q  [RING_N];
    logic [DATA_W-1:0] desc_q [RING_N][BUF_N];

    logic unused_hdr_hi;
    assign unused_hdr_hi = ^wr_data[DATA_W-1:16];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < RING_N; s++) hdr_q[s] <= '0;
        end else if (wr_en && wr_word == '0) begin
            hdr_q[wr_slot] <= hdr_t'(wr_data[15:0]);
        end
    end

    always_ff @(posedge clk) begin
        for (int b = 0; b < BUF_N; b++) begin
            if (wr_en && wr_word == WSEL_W'(b + 1)) desc_q[wr_slot][b] <= wr_data;
        end
    end

    assign rd_hdr = hdr_q[rd_slot];

    for (genvar b = 0; b < BUF_N; b++) begin : g_rd
        assign rd_desc[b*DATA_W +: DATA_W] = desc_q[rd_slot][b];
    end
endmodule

// File: rtl/relring_track.sv
module relring_track
    import relring_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [1:0]       mode,
    input  logic [IDX_W-1:0] prod_idx,
    input  hdr_t             hdr,
    input  logic             out_ready,
    output logic [IDX_W-1:0] cons_idx,
    output logic             out_valid,
    output logic             take,
    output logic             err
);
    logic [IDX_W-1:0] cons_q;
    logic             err_q;
    logic             is_vb, pending, good;

    assign is_vb   = (mode == MODE_VBIT);
    assign pending = is_vb ? (hdr.verb.vbit == cons_q[SLOT_W]) : (prod_idx != cons_q);
    assign good    = verb_ok(hdr.verb);

    assign out_valid = pending && good;
    assign take      = pending && (!good || out_ready);

    always_ff @(posedge clk) begin
        if (rst) begin
            cons_q <= IDX_W'(RING_N);
            err_q  <= 1'b0;
        end else begin
            if (take) cons_q <= cons_q + 1'b1;
            if (pending && !good) err_q <= 1'b1;
        end
    end

    assign cons_idx = cons_q;
    assign err      = err_q;

    // R4
    cons_step_chk: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (cons_q == $past(cons_q)) || (cons_q == $past(cons_q) + 1'b1));

    // R3
    vbit_gate_chk: assert property (@(posedge clk) disable iff (rst)
        (is_vb && hdr.verb.vbit != cons_q[SLOT_W]) |-> (!out_valid && !take));

    // R6
    err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        err_q |=> err_q);

    // R6
    no_empty_out_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (hdr.verb.cnt != 4'd0));
endmodule

// File: rtl/relring_regs.sv
module relring_regs
    import relring_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             reg_we,
    input  logic [1:0]       reg_addr,
    input  logic [7:0]       reg_wdata,
    input  logic [IDX_W-1:0] cons_idx,
    input  logic             take,
    output logic [IDX_W-1:0] prod_idx,
    output logic [1:0]       mode,
    output logic [7:0]       reg_rdata,
    output logic             irq
);
    logic [IDX_W-1:0]  prod_q;
    logic [1:0]        mode_q;
    logic [3:0]        thr_q;
    logic [3:0]        drain_q;
    logic [4:0]        drain_nx;
    logic              irq_q;
    logic [SLOT_W-1:0] free_slots;
    logic              thr_wr;
    logic              unused_wbits;

    assign unused_wbits = ^reg_wdata[7:4];
    assign free_slots   = SLOT_W'(RING_N - 1) - slot_dist(cons_idx[SLOT_W-1:0],
                                                          prod_q[SLOT_W-1:0]);
    assign thr_wr       = reg_we && (reg_addr == REG_THRESH);
    assign drain_nx     = {1'b0, drain_q} + 5'd1;

    always_comb begin
        case (reg_e'(reg_addr))
            REG_PROD:   reg_rdata = {4'd0, prod_q};
            REG_CONS:   reg_rdata = {1'b0, free_slots, cons_idx};
            REG_MODE:   reg_rdata = {6'd0, mode_q};
            REG_THRESH: reg_rdata = {4'd0, thr_q};
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            prod_q  <= IDX_W'(RING_N);
            mode_q  <= MODE_VBIT;
            thr_q   <= '0;
            drain_q <= '0;
            irq_q   <= 1'b0;
        end else begin
            if (reg_we) begin
                case (reg_e'(reg_addr))
                    REG_PROD:   prod_q <= reg_wdata[IDX_W-1:0];
                    REG_MODE:   mode_q <= reg_wdata[1:0];
                    REG_THRESH: begin
                        thr_q   <= reg_wdata[3:0];
                        drain_q <= '0;
                        irq_q   <= 1'b0;
                    end
                    default: ;
                endcase
            end
            if (!thr_wr && take) begin
                if (drain_q != 4'hF) drain_q <= drain_nx[3:0];
                if (thr_q != 4'd0 && drain_nx >= {1'b0, thr_q}) irq_q <= 1'b1;
            end
        end
    end

    assign prod_idx = prod_q;
    assign mode     = mode_q;
    assign irq      = irq_q;

    // R9
    irq_needs_thr_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(irq_q) |-> (thr_q != 4'd0));
endmodule

// File: rtl/relring_consumer.sv
module relring_consumer
    import relring_pkg::*;
#(
    parameter int ADDR_W = 24,
    parameter int POOL_W = 6,
    parameter int DATA_W = 32
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    wr_en,
    input  logic [SLOT_W-1:0]       wr_slot,
    input  logic [WSEL_W-1:0]       wr_word,
    input  logic [DATA_W-1:0]       wr_data,
    input  logic                    reg_we,
    input  logic [1:0]              reg_addr,
    input  logic [7:0]              reg_wdata,
    output logic [7:0]              reg_rdata,
    output logic                    out_valid,
    input  logic                    out_ready,
    output logic [3:0]              out_count,
    output logic [BUF_N*ADDR_W-1:0] out_addr,
    output logic [BUF_N*POOL_W-1:0] out_pool,
    output logic                    err_flag,
    output logic                    ring_irq
);
    localparam int DESC_W = ADDR_W + POOL_W;

    hdr_t                    hdr;
    logic [BUF_N*DATA_W-1:0] desc;
    logic [IDX_W-1:0]        cons_idx, prod_idx;
    logic [1:0]              mode;
    logic                    take;
    logic                    per_buf;
    logic                    unused_hdr_bits;

    relring_store #(.DATA_W(DATA_W)) store_i (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_slot(wr_slot), .wr_word(wr_word),
        .wr_data(wr_data), .rd_slot(cons_idx[SLOT_W-1:0]), .rd_hdr(hdr), .rd_desc(desc)
    );

    relring_track track_i (
        .clk(clk), .rst(rst), .mode(mode), .prod_idx(prod_idx), .hdr(hdr),
        .out_ready(out_ready), .cons_idx(cons_idx), .out_valid(out_valid),
        .take(take), .err(err_flag)
    );

    relring_regs regs_i (
        .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .cons_idx(cons_idx), .take(take), .prod_idx(prod_idx), .mode(mode),
        .reg_rdata(reg_rdata), .irq(ring_irq)
    );

    assign per_buf         = (hdr.verb.cmd == CMD_PER_BUF);
    assign out_count       = hdr.verb.cnt;
    assign unused_hdr_bits = ^{hdr.pool[7:POOL_W], hdr.verb.vbit};

    for (genvar b = 0; b < BUF_N; b++) begin : g_lane
        logic [DATA_W-1:0] word;
        logic              unused_hi;
        assign word      = desc[b*DATA_W +: DATA_W];
        assign unused_hi = ^word[DATA_W-1:DESC_W];
        assign out_addr[b*ADDR_W +: ADDR_W] = word[ADDR_W-1:0];
        assign out_pool[b*POOL_W +: POOL_W] = per_buf ? word[DESC_W-1:ADDR_W]
                                                      : hdr.pool[POOL_W-1:0];
    end
endmodule

// File: tb/relring_consumer_tb_top.sv
module relring_consumer_tb_top;
    localparam int CLK_PERIOD = 10;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         wr_en = 1'b0;
    logic [2:0]   wr_slot = '0;
    logic [3:0]   wr_word = '0;
    logic [31:0]  wr_data = '0;
    logic         reg_we = 1'b0;
    logic [1:0]   reg_addr = '0;
    logic [7:0]   reg_wdata = '0;
    logic [7:0]   reg_rdata;
    logic         out_valid;
    logic         out_ready = 1'b0;
    logic [3:0]   out_count;
    logic [191:0] out_addr;
    logic [47:0]  out_pool;
    logic         err_flag, ring_irq;

    int checks = 0, failures = 0;
    logic [191:0] ea;
    logic [47:0]  ep;
    logic [3:0]   ecnt;
    logic [3:0]   cur;
    logic [3:0]   thr_m, drain_m;
    logic         irq_m;
    logic [7:0]   rv;
    bit           done = 0;

    relring_consumer dut_i (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_slot(wr_slot), .wr_word(wr_word),
        .wr_data(wr_data), .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .out_valid(out_valid), .out_ready(out_ready),
        .out_count(out_count), .out_addr(out_addr), .out_pool(out_pool),
        .err_flag(err_flag), .ring_irq(ring_irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic reg_wr(input logic [1:0] a, input logic [7:0] d);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        tick();
        reg_we = 1'b0;
        if (a == 2'd3) begin
            thr_m = d[3:0]; drain_m = '0; irq_m = 1'b0;
        end
    endtask

    task automatic wr(input logic [2:0] s, input logic [3:0] w, input logic [31:0] d);
        wr_en = 1'b1; wr_slot = s; wr_word = w; wr_data = d;
        tick();
        wr_en = 1'b0;
    endtask

    task automatic put_entry(input logic [2:0] s, input logic vb, input logic [2:0] cmd,
                             input logic [3:0] cnt, input logic [7:0] pool);
        for (int b = 0; b < 8; b++) begin
            logic [23:0] a;
            logic [5:0]  p;
            a = 24'($urandom);
            p = 6'($urandom);
            ea[b*24 +: 24] = a;
            ep[b*6 +: 6]   = (cmd == 3'd3) ? p : pool[5:0];
            wr(s, 4'(b + 1), {2'b00, p, a});
        end
        ecnt = cnt;
        wr(s, 4'd0, {16'd0, pool, vb, cmd, cnt});
    endtask

    function automatic bit is_good(input logic [2:0] cmd, input logic [3:0] cnt);
        return (cmd == 3'd2 || cmd == 3'd3) && cnt >= 4'd1 && cnt <= 4'd8;
    endfunction

    task automatic model_take();
        cur = cur + 4'd1;
        if (drain_m != 4'hF) drain_m = drain_m + 4'd1;
        if (thr_m != 0 && drain_m >= thr_m) irq_m = 1'b1;
    endtask

    task automatic check_cons(input string req);
        rd(2'd1, rv);
        chk(req, rv[3:0], cur);
    endtask

    task automatic consume_good(input string req, input int hold);
        #1;
        chk({req, " R2 valid"}, out_valid, 1);
        chk("R2 count", out_count, ecnt);
        chk("R5 addr lanes", out_addr == ea, 1);
        chk("R5 pool lanes", out_pool, ep);
        for (int h = 0; h < hold; h++) begin
            tick();
            #1;
            chk("R4 hold valid", out_valid, 1);
            check_cons("R4 hold index");
        end
        out_ready = 1'b1;
        tick();
        out_ready = 1'b0;
        model_take();
        check_cons({req, " R4 advance"});
        chk("R9 irq", ring_irq, irq_m);
    endtask

    task automatic drop_bad(input string req);
        #1;
        chk({req, " R6 no valid"}, out_valid, 0);
        check_cons("R6 before drop");
        tick();
        model_take();
        check_cons("R6 dropped in one cycle");
        chk("R6 err sticky", err_flag, 1);
        chk("R9 irq", ring_irq, irq_m);
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=running expected=finished");
            finish_run();
        end
    end

    initial begin
        void'($urandom(32'd7));
        thr_m = 0; drain_m = 0; irq_m = 0; cur = 4'd8;
        repeat (3) tick();
        rst = 1'b0;
        tick();

        // R1 reset state
        rd(2'd1, rv); chk("R1 cons", rv[3:0], 4'd8);
        chk("R8 free at reset", rv[6:4], 3'd7);
        rd(2'd0, rv); chk("R1 prod", rv, 8'd8);
        rd(2'd2, rv); chk("R1 mode", rv, 8'd2);
        rd(2'd3, rv); chk("R1 thresh", rv, 8'd0);
        chk("R1 valid", out_valid, 0);
        chk("R1 err", err_flag, 0);
        chk("R1 irq", ring_irq, 0);

        // R3 wrong polarity ignored
        put_entry(3'd0, 1'b0, 3'd2, 4'd3, 8'h05);
        repeat (3) tick();
        #1; chk("R3 no valid", out_valid, 0);
        check_cons("R3 index held");
        wr(3'd0, 4'd0, {16'd0, 8'h11, 1'b0, 3'd3, 4'd5});
        tick(); #1;
        chk("R3 no valid after rewrite", out_valid, 0);
        check_cons("R3 index held after rewrite");

        // R2/R5 single pool, held for several cycles
        put_entry(3'd0, 1'b1, 3'd2, 4'd3, 8'hC5);
        consume_good("single pool", 3);
        // R5 per-buffer pools
        put_entry(3'd1, 1'b1, 3'd3, 4'd8, 8'h2A);
        consume_good("per-buffer pool", 0);
        // R6 bad command, then count 0
        put_entry(3'd2, 1'b1, 3'd5, 4'd4, 8'h01);
        drop_bad("bad cmd");
        put_entry(3'd3, 1'b1, 3'd2, 4'd0, 8'h01);
        drop_bad("zero count");

        // random mix in valid-bit mode, many ring wraps; R9 with threshold 0 first
        for (int i = 0; i < 60; i++) begin
            int r;
            logic [2:0] cmd;
            logic [3:0] cnt;
            if (i == 20) begin
                reg_wr(2'd3, 8'd3);
                #1; chk("R9 clear on write", ring_irq, 0);
            end
            if (i == 40) begin
                reg_wr(2'd3, 8'd5);
                #1; chk("R9 clear on rewrite", ring_irq, 0);
            end
            r = $urandom % 10;
            if (r == 0) begin
                cmd = 3'(4 + ($urandom % 4)); cnt = 4'(1 + $urandom % 8);
            end else if (r == 1) begin
                cmd = 3'd2; cnt = ($urandom % 2) ? 4'd0 : 4'(9 + $urandom % 7);
            end else begin
                cmd = ($urandom % 2) ? 3'd3 : 3'd2; cnt = 4'(1 + $urandom % 8);
            end
            put_entry(cur[2:0], cur[3], cmd, cnt, 8'($urandom));
            if (is_good(cmd, cnt)) consume_good("random R4 wrap", $urandom % 3);
            else drop_bad("random");
        end

        // index mode: producer == consumer first
        reg_wr(2'd0, {4'd0, cur});
        reg_wr(2'd2, 8'd0);
        rd(2'd2, rv); chk("R7 mode readback", rv, 8'd0);
        for (int k = 2; k >= 0; k--) begin
            logic [3:0] s;
            s = cur + 4'(k);
            put_entry(s[2:0], ~s[3], 3'd2, 4'(k + 2), 8'h33);
        end
        #1; chk("R7 no pending when equal", out_valid, 0);
        check_cons("R7 index held");
        reg_wr(2'd0, {4'd0, cur + 4'd3});
        rd(2'd1, rv); chk("R8 free with three", rv[6:4], 3'd4);
        #1; chk("R7 pending despite vbit", out_valid, 1);
        chk("R7 count", out_count, 4'd2);
        chk("R5 addr lanes index mode", out_addr == ea, 1);
        // R11 consumer register ignores writes
        reg_wr(2'd1, 8'hFF);
        check_cons("R11 read-only");
        // R10 back-to-back
        out_ready = 1'b1;
        for (int k = 0; k < 3; k++) begin
            #1; chk("R10 valid each cycle", out_valid, 1);
            tick();
            model_take();
            check_cons("R10 one per cycle");
        end
        out_ready = 1'b0;
        #1; chk("R7 empty again", out_valid, 0);
        rd(2'd1, rv); chk("R8 free when empty", rv[6:4], 3'd7);
        chk("R9 irq after burst", ring_irq, irq_m);
        chk("R6 err still set", err_flag, 1);

        done = 1;
        finish_run();
    end
endmodule